// File: doc/BRIEF.md
# One-Hot Dependency Matrix Scoreboard

This block tracks register hazards between a small group of function units. It never compares binary register numbers. Each unit keeps its destination and its sources as unary bit vectors. A source vector is multi-hot, because it is the union of up to two operands. Two registers match when a per-bit AND followed by an OR reduction comes out non-zero.

An age matrix records which units issued before which. With it, a unit waits only on older instructions when it reads or writes. It is never held back by younger ones.

The issue port accepts one instruction per clock, in program order. The instruction goes into an idle unit without waiting for earlier instructions to finish. After issue, each unit raises a read grant when its operands are safe to read, and a write grant when its result is safe to write. The unit's execution logic answers each grant with a done pulse. A write-done retires the unit.

The issue port follows valid/ready rules. An instruction moves only in a cycle where `issue_valid` and `issue_ready` are both high. `issue_ready` is worked out from the fields offered on the port and from the held state. It does not depend on `issue_valid`. While `issue_ready` is low the source holds its fields, and that back-pressure lasts as long as the hazard does.

Top module: `onehot_scoreboard`

## Requirements
- R1: `issue_ready` is high only when the unit named by `issue_fu` is idle, and, if `issue_has_dest` is 1, no busy unit's pending destination equals `issue_dest`. A unit that retires in a cycle cannot be issued into during that same cycle.
- R2: A unit accepted at a clock edge is busy from that edge on. Its grants are computed from the stored operands starting in the next cycle.
- R3: `go_rd[i]` is high while unit i has not yet read and no older busy unit has a destination equal to any of unit i's valid sources.
- R4: `go_wr[i]` is high only after unit i has read its operands, and only while no older unit still holds an unread source equal to unit i's destination.
- R5: A `wr_done[i]` pulse given while `go_wr[i]` is high frees unit i and removes it from every age row at that clock edge. Units that waited on it see their grant rise in the following cycle. Units may retire out of issue order.
- R6: A `rd_done[i]` or `wr_done[i]` pulse that arrives while the matching grant is low changes nothing.
- R7: An instruction with `issue_has_dest` = 0 blocks no other unit. It receives `go_wr` as soon as it has read.
- R8: A younger unit never blocks an older one. A later writer of a register that an older unit still reads leaves the older unit's `go_rd` unchanged.
- R9: After reset every unit is idle, `go_rd` and `go_wr` are all zero, and `issue_ready` is high for any offered fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue_valid | input | 1 | An instruction is offered |
| issue_ready | output | 1 | The offered instruction can be accepted this cycle |
| issue_fu | input | 2 | Index of the target function unit |
| issue_has_dest | input | 1 | The instruction writes a register |
| issue_dest | input | 5 | Destination register number |
| issue_src0_vld | input | 1 | First operand is used |
| issue_src0 | input | 5 | First operand register number |
| issue_src1_vld | input | 1 | Second operand is used |
| issue_src1 | input | 5 | Second operand register number |
| go_rd | output | 4 | Per-unit grant to read operands |
| go_wr | output | 4 | Per-unit grant to write the result |
| rd_done | input | 4 | Per-unit pulse: operands have been read |
| wr_done | input | 4 | Per-unit pulse: result written, unit retires |

## Verification
Some properties are checked on every cycle:
- No two busy units ever hold the same destination.
- Each destination vector has at most one bit set.
- The age matrix stays antisymmetric, with an empty diagonal.
- An accepted issue makes its unit busy, and an accepted write-done frees it.
- A unit's read state stays put unless a granted read or an issue occurs.

Other behaviours only show in the bench's scenarios:
- The exact grant patterns around read-after-write, write-after-read and refused write-after-write.
- Out-of-order retirement.
- The one-cycle delay before dependants are released.
- Ignored done pulses.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int unsigned SB_NFU_DEFAULT  = 4;
  localparam int unsigned SB_NREG_DEFAULT = 32;
  localparam int unsigned SB_SRC_PORTS    = 2;
endpackage

// File: rtl/sb_decode.sv
module sb_decode #(
  parameter int unsigned NREG = sb_pkg::SB_NREG_DEFAULT,
  localparam int unsigned AW = $clog2(NREG)
) (
  input  logic [AW-1:0]   idx,
  input  logic            en,
  output logic [NREG-1:0] oh
);
  for (genvar r = 0; r < NREG; r++) begin : g_bit
    assign oh[r] = en && (idx == AW'(r));
  end
endmodule

// File: rtl/sb_fu_row.sv
module sb_fu_row #(
  parameter int unsigned NREG = sb_pkg::SB_NREG_DEFAULT
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [NREG-1:0] ld_dest,
  input  logic [NREG-1:0] ld_src,
  input  logic            rd_fire,
  input  logic            wr_fire,
  output logic            busy,
  output logic            rd_pend,
  output logic [NREG-1:0] dest_oh,
  output logic [NREG-1:0] src_oh
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      rd_pend <= 1'b0;
      dest_oh <= '0;
      src_oh  <= '0;
    end else if (wr_fire) begin
      busy    <= 1'b0;
      rd_pend <= 1'b0;
      dest_oh <= '0;
      src_oh  <= '0;
    end else if (load) begin
      busy    <= 1'b1;
      rd_pend <= 1'b1;
      dest_oh <= ld_dest;
      src_oh  <= ld_src;
    end else if (rd_fire) begin
      rd_pend <= 1'b0;
    end
  end

  assert_load_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (busy && rd_pend));
  assert_retire_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> !busy);
  assert_dest_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dest_oh));
  assert_read_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_fire && !load && !wr_fire) |=> $stable(rd_pend));
endmodule

// File: rtl/sb_age_matrix.sv
module sb_age_matrix #(
  parameter int unsigned NFU = sb_pkg::SB_NFU_DEFAULT
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NFU-1:0]           load,
  input  logic [NFU-1:0]           busy,
  input  logic [NFU-1:0]           free,
  output logic [NFU-1:0][NFU-1:0]  older
);
  for (genvar i = 0; i < NFU; i++) begin : g_row
    for (genvar j = 0; j < NFU; j++) begin : g_col
      if (i == j) begin : g_diag
        assign older[i][j] = 1'b0;
      end else begin : g_cell
        logic cell_q;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)       cell_q <= 1'b0;
          else if (load[i]) cell_q <= busy[j] && !free[j];
          else              cell_q <= cell_q && !free[j] && !free[i];
        end
        assign older[i][j] = cell_q;
        if (j > i) begin : g_pair
          assert_age_antisym_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !(older[i][j] && older[j][i]));
        end
      end
    end
  end
endmodule

// File: rtl/sb_hazard.sv
module sb_hazard #(
  parameter int unsigned NFU  = sb_pkg::SB_NFU_DEFAULT,
  parameter int unsigned NREG = sb_pkg::SB_NREG_DEFAULT
) (
  input  logic [NFU-1:0]            busy,
  input  logic [NFU-1:0]            rd_pend,
  input  logic [NFU-1:0][NREG-1:0]  dest_oh,
  input  logic [NFU-1:0][NREG-1:0]  src_oh,
  input  logic [NFU-1:0][NFU-1:0]   older,
  output logic [NFU-1:0]            go_rd,
  output logic [NFU-1:0]            go_wr
);
  for (genvar i = 0; i < NFU; i++) begin : g_unit
    logic [NFU-1:0] raw_hit;
    logic [NFU-1:0] war_hit;
    for (genvar j = 0; j < NFU; j++) begin : g_pair
      assign raw_hit[j] = older[i][j] && busy[j]    && |(dest_oh[j] & src_oh[i]);
      assign war_hit[j] = older[i][j] && rd_pend[j] && |(src_oh[j] & dest_oh[i]);
    end
    assign go_rd[i] = busy[i] &&  rd_pend[i] && !(|raw_hit);
    assign go_wr[i] = busy[i] && !rd_pend[i] && !(|war_hit);
  end
endmodule

// File: rtl/onehot_scoreboard.sv
module onehot_scoreboard #(
  parameter int unsigned NFU  = sb_pkg::SB_NFU_DEFAULT,
  parameter int unsigned NREG = sb_pkg::SB_NREG_DEFAULT,
  localparam int unsigned AW = $clog2(NREG),
  localparam int unsigned FW = $clog2(NFU)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           issue_valid,
  output logic           issue_ready,
  input  logic [FW-1:0]  issue_fu,
  input  logic           issue_has_dest,
  input  logic [AW-1:0]  issue_dest,
  input  logic           issue_src0_vld,
  input  logic [AW-1:0]  issue_src0,
  input  logic           issue_src1_vld,
  input  logic [AW-1:0]  issue_src1,
  output logic [NFU-1:0] go_rd,
  output logic [NFU-1:0] go_wr,
  input  logic [NFU-1:0] rd_done,
  input  logic [NFU-1:0] wr_done
);
  logic [NREG-1:0]           new_dest, new_s0, new_s1, new_src;
  logic [NFU-1:0]            busy, rd_pend, load, rd_fire, wr_fire;
  logic [NFU-1:0][NREG-1:0]  dest_oh, src_oh;
  logic [NFU-1:0][NFU-1:0]   older;
  logic [NREG-1:0]           pending_dest;
  logic                      waw_clash;

  sb_decode #(.NREG(NREG)) u_dec_dest (.idx(issue_dest), .en(issue_has_dest), .oh(new_dest));
  sb_decode #(.NREG(NREG)) u_dec_s0   (.idx(issue_src0), .en(issue_src0_vld), .oh(new_s0));
  sb_decode #(.NREG(NREG)) u_dec_s1   (.idx(issue_src1), .en(issue_src1_vld), .oh(new_s1));
  assign new_src = new_s0 | new_s1;

  always_comb begin
    pending_dest = '0;
    for (int k = 0; k < NFU; k++) pending_dest |= dest_oh[k];
  end
  assign waw_clash   = |(pending_dest & new_dest);
  assign issue_ready = !busy[issue_fu] && !waw_clash;

  for (genvar i = 0; i < NFU; i++) begin : g_fu
    assign load[i]    = issue_valid && issue_ready && (issue_fu == FW'(i));
    assign rd_fire[i] = rd_done[i] && go_rd[i];
    assign wr_fire[i] = wr_done[i] && go_wr[i];
    sb_fu_row #(.NREG(NREG)) u_row (
      .clk(clk), .rst_n(rst_n), .load(load[i]), .ld_dest(new_dest), .ld_src(new_src),
      .rd_fire(rd_fire[i]), .wr_fire(wr_fire[i]), .busy(busy[i]),
      .rd_pend(rd_pend[i]), .dest_oh(dest_oh[i]), .src_oh(src_oh[i])
    );
    for (genvar j = i + 1; j < NFU; j++) begin : g_waw
      assert_no_waw_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(dest_oh[i] & dest_oh[j])));
    end
  end

  sb_age_matrix #(.NFU(NFU)) u_age (
    .clk(clk), .rst_n(rst_n), .load(load), .busy(busy), .free(wr_fire), .older(older)
  );

  sb_hazard #(.NFU(NFU), .NREG(NREG)) u_haz (
    .busy(busy), .rd_pend(rd_pend), .dest_oh(dest_oh), .src_oh(src_oh),
    .older(older), .go_rd(go_rd), .go_wr(go_wr)
  );
endmodule

// File: tb/onehot_scoreboard_bench.sv
module onehot_scoreboard_bench;
  typedef struct packed {
    logic       iv;
    logic [1:0] fu;
    logic       hd;
    logic [4:0] dst;
    logic       v0;
    logic [4:0] s0;
    logic       v1;
    logic [4:0] s1;
    logic [3:0] rdd;
    logic [3:0] wrd;
    logic       erdy;
    logic [3:0] egr;
    logic [3:0] egw;
  } step_t;

  localparam int NSTEP = 18;
  localparam step_t TBL [NSTEP] = '{
    '{1'b1,2'd0,1'b1,5'd3,1'b1,5'd1,1'b1,5'd2,4'b0000,4'b0000,1'b1,4'b0000,4'b0000}, // R9 R2 r3=r1,r2
    '{1'b1,2'd1,1'b1,5'd5,1'b1,5'd3,1'b1,5'd4,4'b0000,4'b0000,1'b1,4'b0001,4'b0000}, // R3 r5=r3,r4
    '{1'b1,2'd2,1'b1,5'd1,1'b1,5'd6,1'b0,5'd0,4'b0000,4'b0000,1'b1,4'b0001,4'b0000}, // R3 r1=r6
    '{1'b1,2'd3,1'b1,5'd3,1'b0,5'd0,1'b0,5'd0,4'b0100,4'b0000,1'b0,4'b0101,4'b0000}, // R1 WAW r3
    '{1'b0,2'd3,1'b0,5'd0,1'b0,5'd0,1'b0,5'd0,4'b0010,4'b0100,1'b1,4'b0001,4'b0000}, // R4 R6
    '{1'b0,2'd3,1'b0,5'd0,1'b0,5'd0,1'b0,5'd0,4'b0001,4'b0000,1'b1,4'b0001,4'b0000}, // R6
    '{1'b0,2'd3,1'b0,5'd0,1'b0,5'd0,1'b0,5'd0,4'b0000,4'b0100,1'b1,4'b0000,4'b0101}, // R4 R5
    '{1'b1,2'd2,1'b1,5'd4,1'b0,5'd0,1'b0,5'd0,4'b0000,4'b0001,1'b1,4'b0000,4'b0001}, // R5 r4
    '{1'b0,2'd3,1'b0,5'd0,1'b0,5'd0,1'b0,5'd0,4'b0100,4'b0000,1'b1,4'b0110,4'b0000}, // R5 R8
    '{1'b0,2'd3,1'b0,5'd0,1'b0,5'd0,1'b0,5'd0,4'b0010,4'b0000,1'b1,4'b0010,4'b0000}, // R4 WAR
    '{1'b1,2'd0,1'b1,5'd5,1'b0,5'd0,1'b0,5'd0,4'b0000,4'b0010,1'b0,4'b0000,4'b0110}, // R1 R4
    '{1'b1,2'd0,1'b1,5'd5,1'b0,5'd0,1'b0,5'd0,4'b0000,4'b0100,1'b1,4'b0000,4'b0100}, // R1 R5
    '{1'b1,2'd3,1'b0,5'd0,1'b1,5'd5,1'b0,5'd0,4'b0000,4'b0000,1'b1,4'b0001,4'b0000}, // R7
    '{1'b0,2'd2,1'b0,5'd0,1'b0,5'd0,1'b0,5'd0,4'b0001,4'b0000,1'b1,4'b0001,4'b0000}, // R3
    '{1'b0,2'd2,1'b0,5'd0,1'b0,5'd0,1'b0,5'd0,4'b0000,4'b0001,1'b1,4'b0000,4'b0001}, // R4
    '{1'b0,2'd2,1'b0,5'd0,1'b0,5'd0,1'b0,5'd0,4'b1000,4'b0000,1'b1,4'b1000,4'b0000}, // R5
    '{1'b0,2'd2,1'b0,5'd0,1'b0,5'd0,1'b0,5'd0,4'b0000,4'b1000,1'b1,4'b0000,4'b1000}, // R7
    '{1'b0,2'd2,1'b0,5'd0,1'b0,5'd0,1'b0,5'd0,4'b0000,4'b0000,1'b1,4'b0000,4'b0000}  // R5
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic issue_valid = 1'b0, issue_has_dest = 1'b0, issue_src0_vld = 1'b0, issue_src1_vld = 1'b0;
  logic [1:0] issue_fu = '0;
  logic [4:0] issue_dest = '0, issue_src0 = '0, issue_src1 = '0;
  logic [3:0] rd_done = '0, wr_done = '0;
  logic issue_ready;
  logic [3:0] go_rd, go_wr;
  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  onehot_scoreboard u_onehot_scoreboard (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_ready(issue_ready),
    .issue_fu(issue_fu), .issue_has_dest(issue_has_dest), .issue_dest(issue_dest),
    .issue_src0_vld(issue_src0_vld), .issue_src0(issue_src0),
    .issue_src1_vld(issue_src1_vld), .issue_src1(issue_src1),
    .go_rd(go_rd), .go_wr(go_wr), .rd_done(rd_done), .wr_done(wr_done)
  );

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic drive(input step_t s);
    issue_valid = s.iv; issue_fu = s.fu; issue_has_dest = s.hd; issue_dest = s.dst;
    issue_src0_vld = s.v0; issue_src0 = s.s0; issue_src1_vld = s.v1; issue_src1 = s.s1;
    rd_done = s.rdd; wr_done = s.wrd;
  endtask

  function automatic step_t idle_step(input logic [1:0] fu);
    step_t s = '0;
    s.fu = fu;
    return s;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    step_t s;
    drive(idle_step(2'd0));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R9 reset go_rd", go_rd, 4'b0000);
    check("R9 reset go_wr", go_wr, 4'b0000);
    check("R9 reset ready", {3'b0, issue_ready}, 4'b0001);

    for (int k = 0; k < NSTEP; k++) begin
      @(negedge clk);
      drive(TBL[k]);
      #1;
      check($sformatf("step%0d ready R1", k), {3'b0, issue_ready}, {3'b0, TBL[k].erdy});
      check($sformatf("step%0d go_rd R3", k), go_rd, TBL[k].egr);
      check($sformatf("step%0d go_wr R4", k), go_wr, TBL[k].egw);
    end

    // R1: a busy unit refuses a second issue; a free unit accepts
    @(negedge clk);
    s = idle_step(2'd0); s.iv = 1'b1; s.hd = 1'b1; s.dst = 5'd7;
    drive(s);
    #1 check("R1 accept idle unit", {3'b0, issue_ready}, 4'b0001);
    @(negedge clk);
    s.dst = 5'd8;
    drive(s);
    #1 check("R1 busy unit refused", {3'b0, issue_ready}, 4'b0000);
    s.iv = 1'b0; s.fu = 2'd1;
    drive(s);
    #1 check("R1 other unit ready", {3'b0, issue_ready}, 4'b0001);
    check("R2 new unit read grant", go_rd, 4'b0001);

    // R9: reset mid-run clears everything
    rst_n = 1'b0;
    drive(idle_step(2'd0));
    #1;
    check("R9 mid reset go_rd", go_rd, 4'b0000);
    check("R9 mid reset ready", {3'b0, issue_ready}, 4'b0001);
    @(negedge clk);
    rst_n = 1'b1;
    #1 check("R9 after reset go_wr", go_wr, 4'b0000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule